// File: doc/BRIEF.md
# Interrupt Acceptance and Masking Controller

This block sits next to a processor core's sequencer. Each cycle it looks at every event source that wants the core's attention and decides whether one of them is accepted. If one is, it reports which 8-bit vector the core must dispatch through, and whether that dispatch uses an interrupt-style gate or a trap-style gate. An interrupt-style gate means the core will clear its interrupt-enable flag on entry.

There are four event sources:
- synchronous exceptions, which carry their own vector;
- software interrupts, which carry a vector together with the caller's privilege level and the privilege level the gate demands;
- a non-maskable interrupt pin;
- a maskable external request with a vector.

Each source follows its own rules. The enable flag gates only the external request. The non-maskable interrupt is locked out from the moment it is accepted until the core signals a return from interrupt. A software interrupt issued from too weak a privilege level is turned into a protection fault on vector 13.

Requesters hold their request lines until they see the acceptance pulse that carries their vector, and then drop them. The vector table lookup, stack switching and any external interrupt routing are left to other blocks.

Top module: `irq_accept_ctrl`

## Requirements
- R1: `take` is a one-cycle pulse, registered together with `take_vec` and `take_intr_gate`, and it never stays high on two consecutive cycles.
- R2: An exception request is taken with `exc_vec` and `take_intr_gate`=0, whatever the value of `ien`.
- R3: A software interrupt with `swi_cur_pl` <= `swi_gate_pl` (0 is the most privileged level) is taken with `swi_vec` and `take_intr_gate`=0, whatever the value of `ien`.
- R4: A software interrupt with `swi_cur_pl` > `swi_gate_pl` is taken with vector 13 instead of `swi_vec`, with `take_intr_gate`=0.
- R5: A rising edge on `nmi_pin` is taken on vector 2 with `take_intr_gate`=1, even when `ien` is 0.
- R6: Once a non-maskable event is taken, later rising edges on `nmi_pin` are not taken until `iret` has been pulsed. An edge that arrives while blocked is kept pending and taken after the return.
- R7: Several `nmi_pin` edges that arrive while blocked collapse into one pending event.
- R8: The external request is taken with `ext_vec` and `take_intr_gate`=1 only while `ien` is 1. While `ien` is 0 it is left waiting.
- R9: When several sources request in the same cycle, they are taken in this order: exception, then software interrupt, then non-maskable, then external.
- R10: After reset, `take` and `take_vec` are 0, and no non-maskable event is pending or blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request (level) |
| exc_vec | input | 8 | Exception vector |
| swi_req | input | 1 | Software interrupt request (level) |
| swi_vec | input | 8 | Requested software interrupt vector |
| swi_cur_pl | input | 2 | Current privilege level of the caller |
| swi_gate_pl | input | 2 | Privilege level the gate requires |
| nmi_pin | input | 1 | Non-maskable interrupt pin, edge-sensitive |
| ext_req | input | 1 | Maskable external request (level) |
| ext_vec | input | 8 | External request vector |
| ien | input | 1 | Interrupt-enable flag |
| iret | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | Event accepted, one-cycle pulse |
| take_vec | output | 8 | Vector of the accepted event |
| take_intr_gate | output | 1 | 1: interrupt gate, 0: trap gate |

## Verification
The bench builds the block with its default parameters:
- 8-bit vectors;
- 2-bit privilege levels, so all four levels are reachable;
- the protection fault on vector 13;
- the non-maskable interrupt on vector 2.

This range lets the bench reach both outcomes of the privilege comparison: an equal level that passes, and a ring-3 caller against a ring-0 gate that faults. It also lets the vectors used in the exception, software, external and fault cases stay distinct, so each acceptance can be matched to the request it answers.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_EXC  = 3'd1,
    CLS_SWI  = 3'd2,
    CLS_NMI  = 3'd3,
    CLS_EXT  = 3'd4
  } evt_cls_e;
endpackage

// File: rtl/irq_nmi_track.sv
module irq_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic nmi_taken,
  input  logic iret,
  output logic nmi_ready,
  output logic nmi_blocked
);
  logic pin_q;
  logic pend_q;
  logic blk_q;
  logic nmi_edge;

  assign nmi_edge = nmi_pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      pin_q  <= nmi_pin;
      pend_q <= nmi_edge | (pend_q & ~nmi_taken);
      blk_q  <= nmi_taken | (blk_q & ~iret);
    end
  end

  assign nmi_ready   = pend_q & ~blk_q;
  assign nmi_blocked = blk_q;

  // R6: the lock-out only ends on a return strobe
  a_r6_block_held: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !iret) |=> blk_q);
  // R7: a pending event without a take remains pending
  a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !nmi_taken) |=> pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int PL_W    = 2,
  parameter int PF_VEC  = 13,
  parameter int NMI_VEC = 2
) (
  input  logic             hold,
  input  logic             ien,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic             swi_req,
  input  logic [VEC_W-1:0] swi_vec,
  input  logic [PL_W-1:0]  swi_cur_pl,
  input  logic [PL_W-1:0]  swi_gate_pl,
  input  logic             nmi_ready,
  input  logic             ext_req,
  input  logic [VEC_W-1:0] ext_vec,
  output evt_cls_e         grant_cls,
  output logic [VEC_W-1:0] grant_vec,
  output logic             grant_intr_gate
);
  localparam logic [VEC_W-1:0] PF_V  = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  // Lower number = more privileged; a caller may use a gate at its own level or a weaker one.
  function automatic logic priv_ok(input logic [PL_W-1:0] cur, input logic [PL_W-1:0] gate);
    return cur <= gate;
  endfunction

  function automatic evt_cls_e pick(input logic h, input logic e, input logic s,
                                    input logic n, input logic x, input logic en);
    if (h)            return CLS_NONE;
    else if (e)       return CLS_EXC;
    else if (s)       return CLS_SWI;
    else if (n)       return CLS_NMI;
    else if (x && en) return CLS_EXT;
    else              return CLS_NONE;
  endfunction

  always_comb begin
    grant_cls       = pick(hold, exc_req, swi_req, nmi_ready, ext_req, ien);
    grant_vec       = '0;
    grant_intr_gate = 1'b0;
    unique case (grant_cls)
      CLS_EXC: grant_vec = exc_vec;
      CLS_SWI: grant_vec = priv_ok(swi_cur_pl, swi_gate_pl) ? swi_vec : PF_V;
      CLS_NMI: begin grant_vec = NMI_V;   grant_intr_gate = 1'b1; end
      CLS_EXT: begin grant_vec = ext_vec; grant_intr_gate = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int PL_W    = 2,
  parameter int PF_VEC  = 13,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic             swi_req,
  input  logic [VEC_W-1:0] swi_vec,
  input  logic [PL_W-1:0]  swi_cur_pl,
  input  logic [PL_W-1:0]  swi_gate_pl,
  input  logic             nmi_pin,
  input  logic             ext_req,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             ien,
  input  logic             iret,
  output logic             take,
  output logic [VEC_W-1:0] take_vec,
  output logic             take_intr_gate
);
  evt_cls_e         grant_cls;
  logic [VEC_W-1:0] grant_vec;
  logic             grant_intr_gate;
  logic             nmi_ready;
  logic             nmi_blocked;
  logic             nmi_grant;
  evt_cls_e         cls_q;
  logic             take_q;

  assign nmi_grant = (grant_cls == CLS_NMI);

  irq_nmi_track u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_pin    (nmi_pin),
    .nmi_taken  (nmi_grant),
    .iret       (iret),
    .nmi_ready  (nmi_ready),
    .nmi_blocked(nmi_blocked)
  );

  irq_arbiter #(.VEC_W(VEC_W), .PL_W(PL_W), .PF_VEC(PF_VEC), .NMI_VEC(NMI_VEC)) u_arb (
    .hold           (take_q),
    .ien            (ien),
    .exc_req        (exc_req),
    .exc_vec        (exc_vec),
    .swi_req        (swi_req),
    .swi_vec        (swi_vec),
    .swi_cur_pl     (swi_cur_pl),
    .swi_gate_pl    (swi_gate_pl),
    .nmi_ready      (nmi_ready),
    .ext_req        (ext_req),
    .ext_vec        (ext_vec),
    .grant_cls      (grant_cls),
    .grant_vec      (grant_vec),
    .grant_intr_gate(grant_intr_gate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q         <= 1'b0;
      take_vec       <= '0;
      take_intr_gate <= 1'b0;
      cls_q          <= CLS_NONE;
    end else begin
      take_q         <= (grant_cls != CLS_NONE);
      take_vec       <= grant_vec;
      take_intr_gate <= grant_intr_gate;
      cls_q          <= grant_cls;
    end
  end

  assign take = take_q;

  // R1: acceptance is a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R8: an external request is never accepted with the flag clear
  a_r8_ext_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls_q == CLS_EXT) |-> $past(ien));
  // R5: non-maskable events use the fixed vector and an interrupt gate
  a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls_q == CLS_NMI) |-> (take_vec == VEC_W'(NMI_VEC) && take_intr_gate));
  // R6: no non-maskable grant while locked out
  a_r6_no_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blocked |-> !nmi_grant);
  // R4: an under-privileged software interrupt becomes the protection fault
  a_r4_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls_q == CLS_SWI && $past(swi_cur_pl > swi_gate_pl)) |-> take_vec == VEC_W'(PF_VEC));
  // R9: a pending exception always wins
  a_r9_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(exc_req)) |-> cls_q == CLS_EXC);
endmodule

// File: tb/irq_accept_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_accept_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 0, swi_req = 0, nmi_pin = 0, ext_req = 0, ien = 0, iret = 0;
  logic [7:0] exc_vec = 0, swi_vec = 0, ext_vec = 0;
  logic [1:0] swi_cur_pl = 0, swi_gate_pl = 0;
  logic take, take_intr_gate;
  logic [7:0] take_vec;

  int checks = 0, failures = 0, takes_seen = 0, cycles = 0;
  logic prev_take = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_accept_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_vec(exc_vec),
    .swi_req(swi_req), .swi_vec(swi_vec), .swi_cur_pl(swi_cur_pl), .swi_gate_pl(swi_gate_pl),
    .nmi_pin(nmi_pin), .ext_req(ext_req), .ext_vec(ext_vec),
    .ien(ien), .iret(iret),
    .take(take), .take_vec(take_vec), .take_intr_gate(take_intr_gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_take(input logic [7:0] v, input logic g, input string tag);
    exp_q.push_back({g, v});
    tag_q.push_back(tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " expected take missing"}, exp_q.size(), 0);
  endtask

  // Monitor plays the core: compares each take, and lets the answered requester drop.
  always @(negedge clk) begin
    if (rst_n) begin
      if (take && prev_take) chk(1'b0, "R1 take high two cycles", 2, 1);
      if (take) begin
        takes_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R8 unexpected take vec", int'(take_vec), -1);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({take_intr_gate, take_vec} == e, t, int'({take_intr_gate, take_vec}), int'(e));
        end
        if (exc_req && !take_intr_gate && take_vec == exc_vec) exc_req = 0;
        else if (swi_req && !take_intr_gate && (take_vec == swi_vec || take_vec == 8'd13)) swi_req = 0;
        else if (ext_req && take_intr_gate && take_vec == ext_vec) ext_req = 0;
      end
    end
    prev_take = take;
  end

  task automatic nmi_pulse();
    nmi_pin = 1; @(negedge clk); @(negedge clk); nmi_pin = 0; @(negedge clk);
  endtask

  task automatic iret_pulse();
    iret = 1; @(negedge clk); iret = 0;
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk(take == 0, "R10 reset take", take, 0);
    chk(take_vec == 0, "R10 reset vec", take_vec, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(takes_seen == 0, "R10 no take after reset", takes_seen, 0);

    // R8 masked, then enabled
    ext_vec = 8'h40; ext_req = 1; ien = 0;
    repeat (10) @(negedge clk);
    chk(takes_seen == 0 && ext_req, "R8 masked external not taken", takes_seen, 0);
    expect_take(8'h40, 1'b1, "R8 external vec/gate");
    ien = 1;
    drain("R8");
    ien = 0;

    // R2 exception with flag clear
    exc_vec = 8'd14; exc_req = 1;
    expect_take(8'd14, 1'b0, "R2 exception page fault");
    drain("R2");

    // R3 allowed software interrupts
    swi_vec = 8'h80; swi_cur_pl = 2'd3; swi_gate_pl = 2'd3; swi_req = 1;
    expect_take(8'h80, 1'b0, "R3 swi equal privilege");
    drain("R3");
    swi_vec = 8'd3; swi_cur_pl = 2'd0; swi_gate_pl = 2'd3; swi_req = 1;
    expect_take(8'd3, 1'b0, "R3 swi stronger caller");
    drain("R3b");

    // R4 under-privileged
    swi_vec = 8'h80; swi_cur_pl = 2'd3; swi_gate_pl = 2'd0; swi_req = 1;
    expect_take(8'd13, 1'b0, "R4 protection fault vector");
    drain("R4");

    // R5 non-maskable with flag clear
    expect_take(8'd2, 1'b1, "R5 nmi vector 2");
    nmi_pulse();
    drain("R5");

    // R6/R7 blocked until iret; two edges collapse to one
    base = takes_seen;
    nmi_pulse(); nmi_pulse();
    repeat (10) @(negedge clk);
    chk(takes_seen == base, "R6 nmi blocked before iret", takes_seen - base, 0);
    expect_take(8'd2, 1'b1, "R6 pending nmi after iret");
    iret_pulse();
    drain("R6");
    iret_pulse();
    repeat (10) @(negedge clk);
    chk(takes_seen == base + 1, "R7 edges collapse to one", takes_seen - base, 1);

    // R9 all four at once
    ien = 1;
    exc_vec = 8'd6; swi_vec = 8'h81; swi_cur_pl = 0; swi_gate_pl = 0; ext_vec = 8'h41;
    expect_take(8'd6, 1'b0, "R9 exception first");
    expect_take(8'h81, 1'b0, "R9 software second");
    expect_take(8'd2, 1'b1, "R9 nmi third");
    expect_take(8'h41, 1'b1, "R9 external last");
    exc_req = 1; swi_req = 1; ext_req = 1; nmi_pin = 1;
    @(negedge clk); @(negedge clk); nmi_pin = 0;
    drain("R9");
    iret_pulse();
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule